// File: doc/BRIEF.md
# Serial Command Receiver and RAM/Register Write Decoder

This block takes a three-wire serial link from a host controller (active-low select, shift clock, data) and turns it into write strobes for the three display memories and into values for a small set of control registers. The three link signals are brought into the system clock domain through synchroniser chains. Bits are taken least significant first on each rising shift-clock edge while select is low. Every eighth bit closes a byte internally, so the host sends no load strobe.

The first byte after select falls is always a command, with a 3-bit opcode in its top bits. The register commands carry their value in the low bits of that same byte. The three memory commands carry a start address and put the block into a data mode. Code and symbol writes then store one byte per address, and addresses 24 to 31 accept bytes but store nothing. Pattern writes gather five column bytes into one 35-bit dot entry.

Top module: `ser_cmd_decoder`

## Requirements
- R1: While `cs_n` is low, a bit is taken from `sdi` on each rising edge of `sck`, least significant bit first. The eighth bit completes a byte with no further strobe.
- R2: Raising `cs_n` discards a partly received byte, and framing restarts at a byte boundary when it falls again. Shift-clock activity while `cs_n` is high changes no output and produces no write.
- R3: The first byte of each selection is a command, and its opcode is bits 7..5: 001 code write, 010 pattern write, 011 symbol write, 100 port, 101 duty, 110 digit count, 111 override. Opcode 000 changes nothing.
- R4: Code write: bits 4..0 of the command give the start address. Each later byte is written whole to `code_addr`, and then the address steps up by one.
- R5: During code and symbol writes, addresses 24..31 produce no write strobe but still advance. The address wraps from 31 to 0.
- R6: Symbol write: bits 4..0 give the start address, and bits 3..0 of each later byte are written to `sym_data`.
- R7: Pattern write: bits 3..0 give the entry address. The next five bytes are columns j = 0..4, and bit k (k = 0..6) of column j lands in `pat_data` bit j+5k; bit 7 is ignored. One write follows the fifth column, and then the entry address steps up and wraps from 15 to 0.
- R8: Port command sets `gpo` from bits 3..0; duty sets `duty` from bits 2..0; digit count sets `digit_cnt` from bits 3..0; override sets `ovr_lo` from bit 0 and `ovr_hi` from bit 1.
- R9: After reset, `gpo`, `duty` and `digit_cnt` are 0, `ovr_lo` is 1, `ovr_hi` is 0, and no write strobe is active.
- R10: Within one selection, every byte after a non-memory command (including opcode 000) is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Link select, active low, asynchronous |
| sck | input | 1 | Link shift clock, asynchronous |
| sdi | input | 1 | Link serial data, asynchronous |
| code_we | output | 1 | Code RAM write strobe, one cycle |
| code_addr | output | 5 | Code RAM write address |
| code_data | output | 8 | Code RAM write data (character code) |
| pat_we | output | 1 | Pattern RAM write strobe, one cycle |
| pat_addr | output | 4 | Pattern RAM entry address |
| pat_data | output | 35 | Assembled 5x7 dot entry |
| sym_we | output | 1 | Symbol RAM write strobe, one cycle |
| sym_addr | output | 5 | Symbol RAM write address |
| sym_data | output | 4 | Symbol bits |
| gpo | output | 4 | Static general-purpose output |
| duty | output | 3 | Brightness duty setting |
| digit_cnt | output | 4 | Display digit count setting |
| ovr_lo | output | 1 | Force-all-dark flag |
| ovr_hi | output | 1 | Force-all-lit flag |

## Verification
The checks assume that the link obeys its timing. The system clock runs at least four times faster than the shift clock. `sdi` settles well before each rising `sck` edge. `cs_n` changes only while `sck` is low, at least one link phase away from any edge. The stimulus holds every phase of the link for four system cycles and changes data and select only during the low phase. The quiet-select property therefore counts settled cycles of `cs_n` high with a counter, and does not look back a fixed depth.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE = 2'd0,
      MODE_CODE = 2'd1,
      MODE_PAT  = 2'd2,
      MODE_SYM  = 2'd3
   } mode_e;

   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_TEST  = 3'b000;
   localparam logic [OP_W-1:0] OP_CODE  = 3'b001;
   localparam logic [OP_W-1:0] OP_PAT   = 3'b010;
   localparam logic [OP_W-1:0] OP_SYM   = 3'b011;
   localparam logic [OP_W-1:0] OP_PORT  = 3'b100;
   localparam logic [OP_W-1:0] OP_DUTY  = 3'b101;
   localparam logic [OP_W-1:0] OP_DIGIT = 3'b110;
   localparam logic [OP_W-1:0] OP_OVR   = 3'b111;

endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
   parameter int            W       = 3,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/sdc_framer.sv
module sdc_framer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n_s,
   input  logic          sck_s,
   input  logic          sdi_s,
   output logic          byte_vld,
   output logic [DW-1:0] byte_q,
   output logic          first_q
);

   localparam int CNT_W = $clog2(DW);

   logic             sck_d;
   logic             sck_rise;
   logic [CNT_W-1:0] bit_cnt;
   logic [DW-1:0]    shreg;
   logic [DW-1:0]    shreg_nx;

   assign sck_rise = sck_s & ~sck_d;
   assign shreg_nx = {sdi_s, shreg[DW-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         byte_q   <= '0;
         first_q  <= 1'b1;
      end else begin
         sck_d    <= sck_s;
         byte_vld <= 1'b0;
         if (sel_n_s) begin
            bit_cnt <= '0;
            first_q <= 1'b1;
         end else begin
            if (byte_vld) first_q <= 1'b0;
            if (sck_rise) begin
               shreg <= shreg_nx;
               if (bit_cnt == CNT_W'(DW-1)) begin
                  byte_vld <= 1'b1;
                  byte_q   <= shreg_nx;
                  bit_cnt  <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sdc_exec.sv
module sdc_exec
   import sdc_pkg::*;
#(
   parameter int DW         = 8,
   parameter int CODE_AW    = 5,
   parameter int CODE_DEPTH = 24,
   parameter int PAT_AW     = 4,
   parameter int PAT_COLS   = 5,
   parameter int PAT_ROWS   = 7,
   parameter int SYM_W      = 4,
   parameter int PORT_W     = 4,
   parameter int DUTY_W     = 3,
   parameter int DIG_W      = 4,
   localparam int PAT_W     = PAT_COLS * PAT_ROWS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               byte_vld,
   input  logic [DW-1:0]      byte_in,
   input  logic               first,
   output logic               code_we,
   output logic [CODE_AW-1:0] code_addr,
   output logic [DW-1:0]      code_data,
   output logic               pat_we,
   output logic [PAT_AW-1:0]  pat_addr,
   output logic [PAT_W-1:0]   pat_data,
   output logic               sym_we,
   output logic [CODE_AW-1:0] sym_addr,
   output logic [SYM_W-1:0]   sym_data,
   output logic [PORT_W-1:0]  gpo,
   output logic [DUTY_W-1:0]  duty,
   output logic [DIG_W-1:0]   digit_cnt,
   output logic               ovr_lo,
   output logic               ovr_hi
);

   localparam int COL_W = $clog2(PAT_COLS);
   localparam logic [CODE_AW:0] CODE_LIM = (CODE_AW+1)'(CODE_DEPTH);

   mode_e              mode;
   logic [CODE_AW-1:0] code_ptr;
   logic [CODE_AW-1:0] sym_ptr;
   logic [PAT_AW-1:0]  pat_ptr;
   logic [COL_W-1:0]   col;
   logic [PAT_W-1:0]   pat_acc;
   logic [PAT_W-1:0]   pat_nx;
   logic [OP_W-1:0]    op;

   assign op = byte_in[DW-1 -: OP_W];

   always_comb begin
      pat_nx = pat_acc;
      for (int k = 0; k < PAT_ROWS; k++) begin
         pat_nx[int'(col) + PAT_COLS*k] = byte_in[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= MODE_IDLE;
         code_ptr  <= '0;
         sym_ptr   <= '0;
         pat_ptr   <= '0;
         col       <= '0;
         pat_acc   <= '0;
         code_we   <= 1'b0;
         code_addr <= '0;
         code_data <= '0;
         pat_we    <= 1'b0;
         pat_addr  <= '0;
         pat_data  <= '0;
         sym_we    <= 1'b0;
         sym_addr  <= '0;
         sym_data  <= '0;
         gpo       <= '0;
         duty      <= '0;
         digit_cnt <= '0;
         ovr_lo    <= 1'b1;
         ovr_hi    <= 1'b0;
      end else begin
         code_we <= 1'b0;
         pat_we  <= 1'b0;
         sym_we  <= 1'b0;
         if (byte_vld) begin
            if (first || mode == MODE_IDLE) begin
               mode <= MODE_IDLE;
               case (op)
                  OP_CODE: begin
                     mode     <= MODE_CODE;
                     code_ptr <= byte_in[CODE_AW-1:0];
                  end
                  OP_PAT: begin
                     mode    <= MODE_PAT;
                     pat_ptr <= byte_in[PAT_AW-1:0];
                     col     <= '0;
                  end
                  OP_SYM: begin
                     mode    <= MODE_SYM;
                     sym_ptr <= byte_in[CODE_AW-1:0];
                  end
                  OP_PORT:  gpo       <= byte_in[PORT_W-1:0];
                  OP_DUTY:  duty      <= byte_in[DUTY_W-1:0];
                  OP_DIGIT: digit_cnt <= byte_in[DIG_W-1:0];
                  OP_OVR: begin
                     ovr_lo <= byte_in[0];
                     ovr_hi <= byte_in[1];
                  end
                  default: ;
               endcase
            end else begin
               case (mode)
                  MODE_CODE: begin
                     if ({1'b0, code_ptr} < CODE_LIM) begin
                        code_we   <= 1'b1;
                        code_addr <= code_ptr;
                        code_data <= byte_in;
                     end
                     code_ptr <= code_ptr + 1'b1;
                  end
                  MODE_SYM: begin
                     if ({1'b0, sym_ptr} < CODE_LIM) begin
                        sym_we   <= 1'b1;
                        sym_addr <= sym_ptr;
                        sym_data <= byte_in[SYM_W-1:0];
                     end
                     sym_ptr <= sym_ptr + 1'b1;
                  end
                  MODE_PAT: begin
                     pat_acc <= pat_nx;
                     if (col == COL_W'(PAT_COLS-1)) begin
                        pat_we   <= 1'b1;
                        pat_addr <= pat_ptr;
                        pat_data <= pat_nx;
                        pat_ptr  <= pat_ptr + 1'b1;
                        col      <= '0;
                     end else begin
                        col <= col + 1'b1;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ser_cmd_decoder.sv
module ser_cmd_decoder #(
   parameter int DW          = 8,
   parameter int CODE_AW     = 5,
   parameter int CODE_DEPTH  = 24,
   parameter int PAT_AW      = 4,
   parameter int PAT_COLS    = 5,
   parameter int PAT_ROWS    = 7,
   parameter int SYM_W       = 4,
   parameter int PORT_W      = 4,
   parameter int DUTY_W      = 3,
   parameter int DIG_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int PAT_W      = PAT_COLS * PAT_ROWS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_n,
   input  logic               sck,
   input  logic               sdi,
   output logic               code_we,
   output logic [CODE_AW-1:0] code_addr,
   output logic [DW-1:0]      code_data,
   output logic               pat_we,
   output logic [PAT_AW-1:0]  pat_addr,
   output logic [PAT_W-1:0]   pat_data,
   output logic               sym_we,
   output logic [CODE_AW-1:0] sym_addr,
   output logic [SYM_W-1:0]   sym_data,
   output logic [PORT_W-1:0]  gpo,
   output logic [DUTY_W-1:0]  duty,
   output logic [DIG_W-1:0]   digit_cnt,
   output logic               ovr_lo,
   output logic               ovr_hi
);

   generate
      if (CODE_AW + sdc_pkg::OP_W > DW) begin : g_bad_aw
         $error("address field overlaps the opcode");
      end
      if (PAT_ROWS > DW - 1 || PAT_AW > CODE_AW) begin : g_bad_pat
         $error("pattern geometry does not fit a byte");
      end
      if (CODE_DEPTH > (1 << CODE_AW) || SYM_W > DW) begin : g_bad_depth
         $error("memory depth or symbol width out of range");
      end
      if (PORT_W > DW - 3 || DUTY_W > DW - 3 || DIG_W > DW - 3) begin : g_bad_reg
         $error("register field overlaps the opcode");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchroniser stages are needed");
      end
   endgenerate

   logic [2:0]    link_s;
   logic          byte_vld;
   logic [DW-1:0] byte_q;
   logic          first_q;

   sdc_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, sdi}),
      .q     (link_s)
   );

   sdc_framer #(.DW(DW)) framer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n_s  (link_s[2]),
      .sck_s    (link_s[1]),
      .sdi_s    (link_s[0]),
      .byte_vld (byte_vld),
      .byte_q   (byte_q),
      .first_q  (first_q)
   );

   sdc_exec #(
      .DW         (DW),
      .CODE_AW    (CODE_AW),
      .CODE_DEPTH (CODE_DEPTH),
      .PAT_AW     (PAT_AW),
      .PAT_COLS   (PAT_COLS),
      .PAT_ROWS   (PAT_ROWS),
      .SYM_W      (SYM_W),
      .PORT_W     (PORT_W),
      .DUTY_W     (DUTY_W),
      .DIG_W      (DIG_W)
   ) exec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_in   (byte_q),
      .first     (first_q),
      .code_we   (code_we),
      .code_addr (code_addr),
      .code_data (code_data),
      .pat_we    (pat_we),
      .pat_addr  (pat_addr),
      .pat_data  (pat_data),
      .sym_we    (sym_we),
      .sym_addr  (sym_addr),
      .sym_data  (sym_data),
      .gpo       (gpo),
      .duty      (duty),
      .digit_cnt (digit_cnt),
      .ovr_lo    (ovr_lo),
      .ovr_hi    (ovr_hi)
   );

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
   parameter int CODE_AW    = 5,
   parameter int CODE_DEPTH = 24,
   parameter int PORT_W     = 4,
   parameter int DUTY_W     = 3,
   parameter int DIG_W      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n,
   input logic               code_we,
   input logic [CODE_AW-1:0] code_addr,
   input logic               pat_we,
   input logic               sym_we,
   input logic [CODE_AW-1:0] sym_addr,
   input logic [PORT_W-1:0]  gpo,
   input logic [DUTY_W-1:0]  duty,
   input logic [DIG_W-1:0]   digit_cnt,
   input logic               ovr_lo,
   input logic               ovr_hi
);

   localparam int QUIET_MIN = 8;

   logic [3:0] quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                quiet_cnt <= '0;
      else if (!cs_n)            quiet_cnt <= '0;
      else if (quiet_cnt != 4'hF) quiet_cnt <= quiet_cnt + 1'b1;
   end

   AST_CODE_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      code_we |-> (int'(code_addr) < CODE_DEPTH)); // R5

   AST_SYM_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      sym_we |-> (int'(sym_addr) < CODE_DEPTH)); // R5

   AST_ONE_WRITE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({code_we, pat_we, sym_we})); // R3

   AST_CODE_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      code_we |=> !code_we); // R4

   AST_PAT_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      pat_we |=> !pat_we); // R7

   AST_SYM_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      sym_we |=> !sym_we); // R6

   AST_QUIET_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= QUIET_MIN) |-> (!code_we && !pat_we && !sym_we &&
         $stable(gpo) && $stable(duty) && $stable(digit_cnt) &&
         $stable(ovr_lo) && $stable(ovr_hi))); // R2

endmodule

bind ser_cmd_decoder sdc_checker #(
   .CODE_AW    (CODE_AW),
   .CODE_DEPTH (CODE_DEPTH),
   .PORT_W     (PORT_W),
   .DUTY_W     (DUTY_W),
   .DIG_W      (DIG_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .code_we   (code_we),
   .code_addr (code_addr),
   .pat_we    (pat_we),
   .sym_we    (sym_we),
   .sym_addr  (sym_addr),
   .gpo       (gpo),
   .duty      (duty),
   .digit_cnt (digit_cnt),
   .ovr_lo    (ovr_lo),
   .ovr_hi    (ovr_hi)
);

// File: tb/ser_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module ser_cmd_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sck = 1'b0;
   logic        sdi = 1'b0;
   logic        code_we, pat_we, sym_we;
   logic [4:0]  code_addr, sym_addr;
   logic [7:0]  code_data;
   logic [3:0]  pat_addr;
   logic [34:0] pat_data;
   logic [3:0]  sym_data;
   logic [3:0]  gpo, digit_cnt;
   logic [2:0]  duty;
   logic        ovr_lo, ovr_hi;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // expected write: {kind[1:0], addr[4:0], data[34:0]}; kind 1 code, 2 pattern, 3 symbol
   logic [41:0] exp_q[$];

   always #2 clk = ~clk;

   ser_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .code_we(code_we), .code_addr(code_addr), .code_data(code_data),
      .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data),
      .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
      .gpo(gpo), .duty(duty), .digit_cnt(digit_cnt),
      .ovr_lo(ovr_lo), .ovr_hi(ovr_hi)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sel_low();
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic sel_high();
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(12);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nbits);
      for (int i = 0; i < nbits; i++) begin
         sdi = b[i];
         wait_clk(4);
         sck = 1'b1;
         wait_clk(4);
         sck = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      send_bits(b, 8);
   endtask

   task automatic push_exp(input logic [1:0] kind, input logic [4:0] addr, input logic [34:0] data);
      exp_q.push_back({kind, addr, data});
   endtask

   function automatic logic [34:0] pat_of(input logic [7:0] c0, input logic [7:0] c1,
                                          input logic [7:0] c2, input logic [7:0] c3,
                                          input logic [7:0] c4);
      logic [34:0] r;
      logic [7:0]  c [5];
      c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3; c[4] = c4;
      r = '0;
      for (int j = 0; j < 5; j++)
         for (int k = 0; k < 7; k++)
            r[j + 5*k] = c[j][k];
      return r;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (code_we || pat_we || sym_we)) begin
         logic [41:0] got;
         if (code_we)     got = {2'd1, code_addr, 27'd0, code_data};
         else if (pat_we) got = {2'd2, 1'b0, pat_addr, pat_data};
         else             got = {2'd3, sym_addr, 31'd0, sym_data};
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R2/R5 unexpected write actual=%0h expected=none", got);
         end else begin
            check("R4/R5/R6/R7 write", 64'(got), 64'(exp_q.pop_front()));
         end
      end
   end

   initial begin
      logic [7:0] cols [10];
      wait_clk(5);
      // R9: reset state
      check("R9 gpo", 64'(gpo), 64'h0);
      check("R9 duty", 64'(duty), 64'h0);
      check("R9 digit_cnt", 64'(digit_cnt), 64'h0);
      check("R9 ovr", 64'({ovr_hi, ovr_lo}), 64'h1);
      check("R9 no write", 64'({code_we, pat_we, sym_we}), 64'h0);
      rst_n = 1'b1;
      wait_clk(5);

      // R4 R1: plain code write from address 3
      push_exp(2'd1, 5'd3, 35'hA5);
      push_exp(2'd1, 5'd4, 35'h3C);
      push_exp(2'd1, 5'd5, 35'hFF);
      sel_low();
      send_byte(8'h23);
      send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF);
      sel_high();

      // R5: code write from 22, dummies 24..31, wrap to 0
      push_exp(2'd1, 5'd22, 35'h11);
      push_exp(2'd1, 5'd23, 35'h22);
      push_exp(2'd1, 5'd0, 35'h99);
      sel_low();
      send_byte(8'h36);
      send_byte(8'h11); send_byte(8'h22);
      for (int i = 0; i < 8; i++) send_byte(8'h40 + 8'(i));
      send_byte(8'h99);
      sel_high();

      // R6 R5: symbol write from 23, upper bits ignored, wrap to 0
      push_exp(2'd3, 5'd23, 35'h6);
      push_exp(2'd3, 5'd0, 35'h9);
      sel_low();
      send_byte(8'h77);
      send_byte(8'hF6);
      for (int i = 0; i < 8; i++) send_byte(8'h0F);
      send_byte(8'hA9);
      sel_high();

      // R7: two pattern entries from 15, wrap to 0, bit 7 ignored
      cols[0] = 8'h81; cols[1] = 8'h7F; cols[2] = 8'h2A; cols[3] = 8'hD5; cols[4] = 8'h40;
      cols[5] = 8'h01; cols[6] = 8'h02; cols[7] = 8'hC4; cols[8] = 8'h08; cols[9] = 8'h70;
      push_exp(2'd2, 5'd15, pat_of(cols[0], cols[1], cols[2], cols[3], cols[4]));
      push_exp(2'd2, 5'd0,  pat_of(cols[5], cols[6], cols[7], cols[8], cols[9]));
      sel_low();
      send_byte(8'h4F);
      for (int i = 0; i < 10; i++) send_byte(cols[i]);
      sel_high();
      check("R7 all pattern writes seen", 64'(exp_q.size()), 64'h0);

      // R2: partial byte then deselect; framing restarts
      sel_low();
      send_bits(8'h07, 3);
      sel_high();
      sel_low();
      send_byte(8'h8A);
      sel_high();
      check("R2 realign after abort gpo", 64'(gpo), 64'hA);

      // R2: shift clock activity while deselected is ignored
      for (int i = 0; i < 16; i++) begin
         sdi = 1'b1; wait_clk(4); sck = 1'b1; wait_clk(4); sck = 1'b0;
      end
      wait_clk(12);
      check("R2 deselected gpo", 64'(gpo), 64'hA);
      check("R2 deselected duty", 64'(duty), 64'h0);

      // R8 R10: chain of register commands in one selection
      sel_low();
      send_byte(8'h83);
      send_byte(8'hA2);
      send_byte(8'hCE);
      send_byte(8'hE2);
      sel_high();
      check("R8 gpo", 64'(gpo), 64'h3);
      check("R8 R10 duty", 64'(duty), 64'h2);
      check("R8 R10 digit_cnt", 64'(digit_cnt), 64'hE);
      check("R8 R10 override hi/lo", 64'({ovr_hi, ovr_lo}), 64'h2);

      // R3 R10: opcode 000 ignored, next byte is a command
      sel_low();
      send_byte(8'h1F);
      check("R3 test opcode leaves gpo", 64'(gpo), 64'h3);
      send_byte(8'hA5);
      send_byte(8'hE1);
      sel_high();
      check("R3 R10 duty after test opcode", 64'(duty), 64'h5);
      check("R3 digit_cnt unchanged", 64'(digit_cnt), 64'hE);
      check("R8 override lo", 64'({ovr_hi, ovr_lo}), 64'h1);

      // R3 R1: new selection after RAM mode starts with a command
      sel_low();
      send_byte(8'h85);
      sel_high();
      check("R3 command after data mode", 64'(gpo), 64'h5);
      check("R5 no pending writes", 64'(exp_q.size()), 64'h0);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule